// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor and Port Selector

This block watches the digitized receive pulse from the twisted-pair squelch and decides whether a live 10BASE-T partner is attached. A pulse counts as a link beat only when its width is inside a narrow band. Beats that follow the last accepted one too soon are treated as noise and discarded. Beats that arrive after a long silence are accepted, but they restart the count of consecutive beats. The link is declared good after a set number of consecutive, well-spaced beats. It is declared lost when neither an accepted beat nor frame activity has been seen for the loss interval.

While the local transmitter is idle, the block requests periodic outgoing link test pulses. It also chooses between the twisted-pair port and the AUI port. In automatic mode the link state picks the port, and the choice is reported on a pin driven by the block. In manual mode a pin chosen by the board picks the port. A manual AUI choice stops the outgoing link pulses. An automatic AUI choice keeps them running, so that a partner can still bring the link up.

Every port change is followed by a settle window before the new port is ready. The link and polarity flags are active low and come with an output enable. The pad drives high impedance whenever AUI is selected or the block is in standby. All timers are parameters counted in 20 MHz sample cycles. The block has no streaming data path, so every pin is a plain level or pulse.

Top module: `lnk_monitor`

## Requirements
- R1: A receive pulse is a beat candidate only if it stays high for W_MIN to W_MAX sample cycles, both inclusive. Pulses that occur while rx_frame_i is high are ignored.
- R2: A beat whose separation from the previous accepted beat is less than SEP_MIN cycles is noise. It does not count toward the run, it does not restart the separation measurement, and it does not refresh the loss timer.
- R3: A beat separated from the previous accepted beat by more than SEP_MAX cycles is accepted, but it restarts the consecutive run at one.
- R4: After GOOD_BEATS consecutive beats, each separated from the previous one by SEP_MIN to SEP_MAX cycles, the link becomes good and link_n_o goes low (0 = link good, 1 = link failed).
- R5: When LOSS cycles pass with no accepted beat and no rx_frame_i activity, the link fails and link_n_o goes high. Frame activity alone keeps a good link alive.
- R6: While link pulses are enabled and tx_en_i is low, lp_o goes high for TX_LEN cycles, once every TX_GAP cycles. A high tx_en_i suppresses the pulses and restarts the interval.
- R7: In automatic mode (auto_sel_i=1), port_tp_o follows the link state (1 = twisted pair, 0 = AUI), and port_oe_o is high so that the pin is driven.
- R8: In manual mode, port_tp_o follows man_tp_i. A manual AUI choice stops lp_o. An automatic AUI choice keeps lp_o running.
- R9: After every change of port_tp_o, port_ready_o stays low for exactly SETTLE cycles.
- R10: pol_n_o is the inverse of pol_rev_i while the link is good (0 = reversed pair), and it is forced to 1 while the link has failed.
- R11: flag_oe_o is high only while twisted pair is selected and standby_i is low. Standby clears the link state and stops lp_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_pulse_i | input | 1 | Digitized positive receive pulse from the squelch |
| rx_frame_i | input | 1 | Receive frame carrier activity |
| tx_en_i | input | 1 | Local transmitter busy |
| pol_rev_i | input | 1 | Receive pair reversal detected |
| auto_sel_i | input | 1 | 1 = automatic port choice |
| man_tp_i | input | 1 | Manual choice, 1 = twisted pair |
| standby_i | input | 1 | Low-power standby |
| link_n_o | output | 1 | Link flag, 0 = good |
| pol_n_o | output | 1 | Polarity flag, 0 = reversed pair |
| flag_oe_o | output | 1 | Output enable for link_n_o and pol_n_o |
| lp_o | output | 1 | Link test pulse request to the transmitter |
| port_tp_o | output | 1 | Selected port, 1 = twisted pair |
| port_oe_o | output | 1 | Drive enable for the port-select pin |
| port_ready_o | output | 1 | New port has settled |

## Verification
The bench builds the block with W_MIN=2, W_MAX=4, SEP_MIN=20, SEP_MAX=100, LOSS=150, GOOD_BEATS=2, TX_GAP=60, TX_LEN=3 and SETTLE=10. These values shrink the millisecond windows to tens of sample cycles. With them, a run of beats can cross the too-close, in-window and too-far spacings, a link loss, several outgoing pulse periods and a full settle window within a few thousand cycles. The values are chosen so that the separation windows and the loss interval can be told apart: a far beat (128 cycles) arrives before the loss timer expires (150), so restarting the run can be observed on its own.

// File: rtl/lnkmon_pkg.sv
package lnkmon_pkg;
  typedef enum logic {
    PORT_AUI = 1'b0,
    PORT_TP  = 1'b1
  } port_e;
endpackage

// File: rtl/lnk_pulse_qual.sv
module lnk_pulse_qual #(
  parameter int W_MIN = 1,
  parameter int W_MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  input  logic frame_i,
  output logic beat_o
);
  localparam int WW = $clog2(W_MAX + 2);
  localparam logic [WW-1:0] WSAT = WW'(W_MAX + 1);
  localparam logic [WW-1:0] WLO  = WW'(W_MIN);
  localparam logic [WW-1:0] WHI  = WW'(W_MAX);

  logic [WW-1:0] wid_q;
  logic          fall;

  assign fall = !pulse_i && (wid_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wid_q  <= '0;
      beat_o <= 1'b0;
    end else begin
      if (pulse_i && !frame_i)
        wid_q <= (wid_q == WSAT) ? wid_q : wid_q + 1'b1;
      else
        wid_q <= '0;
      beat_o <= fall && !frame_i && (wid_q >= WLO) && (wid_q <= WHI);
    end
  end

  // R1: a qualified beat is a single-cycle event
  assert_beat_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    beat_o |=> !beat_o);
endmodule

// File: rtl/lnk_beat_track.sv
module lnk_beat_track #(
  parameter int SEP_MIN    = 60000,
  parameter int SEP_MAX    = 3000000,
  parameter int LOSS       = 2400000,
  parameter int GOOD_BEATS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic beat_i,
  input  logic frame_i,
  output logic link_good_o
);
  localparam int GW = $clog2(SEP_MAX + 2);
  localparam int IW = $clog2(LOSS + 1);
  localparam int RW = $clog2(GOOD_BEATS + 1);
  localparam logic [GW-1:0] GSAT   = GW'(SEP_MAX + 1);
  localparam logic [GW-1:0] SMIN_C = GW'(SEP_MIN);
  localparam logic [GW-1:0] SMAX_C = GW'(SEP_MAX);
  localparam logic [IW-1:0] LOSS_C = IW'(LOSS);
  localparam logic [RW-1:0] GOOD_C = RW'(GOOD_BEATS);
  localparam logic [RW-1:0] ONE_R  = RW'(1);

  logic [GW-1:0] gap_q;
  logic [IW-1:0] idle_q;
  logic [RW-1:0] run_q, run_nx;
  logic          noise, take, far, expired;

  assign noise   = beat_i && (gap_q < SMIN_C);
  assign take    = beat_i && !noise;
  assign far     = gap_q > SMAX_C;
  assign expired = idle_q == LOSS_C;

  always_comb begin
    run_nx = run_q;
    if (take) begin
      if (far)                run_nx = ONE_R;
      else if (run_q < GOOD_C) run_nx = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q       <= GSAT;
      idle_q      <= '0;
      run_q       <= '0;
      link_good_o <= 1'b0;
    end else if (clear_i) begin
      gap_q       <= GSAT;
      idle_q      <= '0;
      run_q       <= '0;
      link_good_o <= 1'b0;
    end else begin
      if (take)               gap_q <= GW'(1);
      else if (gap_q != GSAT) gap_q <= gap_q + 1'b1;

      if (take || frame_i) idle_q <= '0;
      else if (!expired)   idle_q <= idle_q + 1'b1;

      if (expired) begin
        run_q       <= take ? ONE_R : '0;
        link_good_o <= take && (GOOD_BEATS <= 1);
      end else begin
        run_q <= run_nx;
        if (run_nx >= GOOD_C) link_good_o <= 1'b1;
      end
    end
  end

  // R2: a too-close beat leaves the run untouched
  assert_noise_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (noise && !expired && !clear_i) |=> $stable(run_q));
  // R4: the link only comes up on a beat
  assert_link_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_good_o) |-> $past(beat_i));
  // R5: an expired loss timer takes the link down
  assert_loss_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !take) |=> !link_good_o);
endmodule

// File: rtl/lnk_tx_pulser.sv
module lnk_tx_pulser #(
  parameter int GAP = 320000,
  parameter int LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tx_en_i,
  output logic lp_o
);
  localparam int CW = $clog2(GAP);
  localparam int LW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(GAP - 1);
  localparam logic [LW-1:0] LEN_C = LW'(LEN);

  logic [CW-1:0] cnt_q;
  logic [LW-1:0] len_q;
  logic          fire;

  assign fire = en_i && !tx_en_i && (cnt_q == LAST);
  assign lp_o = len_q != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= '0;
    end else begin
      if (!en_i || tx_en_i || fire) cnt_q <= '0;
      else                          cnt_q <= cnt_q + 1'b1;

      if (!en_i)          len_q <= '0;
      else if (fire)      len_q <= LEN_C;
      else if (len_q != 0) len_q <= len_q - 1'b1;
    end
  end

  // R6: a pulse only starts while the transmitter is idle
  assert_start_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lp_o) |-> !$past(tx_en_i));
  // R8: no pulse once pulses are disabled
  assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_i) |-> !lp_o);
endmodule

// File: rtl/lnk_port_sel.sv
module lnk_port_sel
  import lnkmon_pkg::*;
#(
  parameter int SETTLE = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_i,
  input  logic man_tp_i,
  input  logic link_good_i,
  output logic sel_tp_o,
  output logic ready_o
);
  localparam int SW = $clog2(SETTLE + 1);
  localparam logic [SW-1:0] SET_C = SW'(SETTLE);

  port_e         sel_q, want;
  logic [SW-1:0] wait_q;

  assign want     = (auto_i ? link_good_i : man_tp_i) ? PORT_TP : PORT_AUI;
  assign sel_tp_o = sel_q == PORT_TP;
  assign ready_o  = wait_q == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= PORT_AUI;
      wait_q <= '0;
    end else begin
      sel_q <= want;
      if (want != sel_q)    wait_q <= SET_C;
      else if (wait_q != 0) wait_q <= wait_q - 1'b1;
    end
  end

  // R9: a port change always opens the settle window
  assert_settle_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> !ready_o);
endmodule

// File: rtl/lnk_monitor.sv
module lnk_monitor #(
  parameter int W_MIN      = 1,
  parameter int W_MAX      = 4,
  parameter int SEP_MIN    = 60000,
  parameter int SEP_MAX    = 3000000,
  parameter int LOSS       = 2400000,
  parameter int GOOD_BEATS = 2,
  parameter int TX_GAP     = 320000,
  parameter int TX_LEN     = 2,
  parameter int SETTLE     = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_pulse_i,
  input  logic rx_frame_i,
  input  logic tx_en_i,
  input  logic pol_rev_i,
  input  logic auto_sel_i,
  input  logic man_tp_i,
  input  logic standby_i,
  output logic link_n_o,
  output logic pol_n_o,
  output logic flag_oe_o,
  output logic lp_o,
  output logic port_tp_o,
  output logic port_oe_o,
  output logic port_ready_o
);
  logic beat, link_good, lp_en;

  lnk_pulse_qual #(.W_MIN(W_MIN), .W_MAX(W_MAX)) u_qual (
    .clk(clk), .rst_n(rst_n), .pulse_i(rx_pulse_i), .frame_i(rx_frame_i),
    .beat_o(beat));

  lnk_beat_track #(.SEP_MIN(SEP_MIN), .SEP_MAX(SEP_MAX), .LOSS(LOSS),
                   .GOOD_BEATS(GOOD_BEATS)) u_track (
    .clk(clk), .rst_n(rst_n), .clear_i(standby_i), .beat_i(beat),
    .frame_i(rx_frame_i), .link_good_o(link_good));

  assign lp_en = !standby_i && (auto_sel_i || man_tp_i);

  lnk_tx_pulser #(.GAP(TX_GAP), .LEN(TX_LEN)) u_pulser (
    .clk(clk), .rst_n(rst_n), .en_i(lp_en), .tx_en_i(tx_en_i), .lp_o(lp_o));

  lnk_port_sel #(.SETTLE(SETTLE)) u_port (
    .clk(clk), .rst_n(rst_n), .auto_i(auto_sel_i), .man_tp_i(man_tp_i),
    .link_good_i(link_good), .sel_tp_o(port_tp_o), .ready_o(port_ready_o));

  assign link_n_o  = !link_good;
  assign pol_n_o   = link_good ? !pol_rev_i : 1'b1;
  assign flag_oe_o = port_tp_o && !standby_i;
  assign port_oe_o = auto_sel_i && !standby_i;

  // R10: a failed link never reports a polarity fault
  assert_pol_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    link_n_o |-> pol_n_o);
endmodule

// File: tb/lnk_monitor_tb.sv
module lnk_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int P_SETTLE = 10;
  localparam int P_GAP = 60;
  localparam int P_LEN = 3;
  localparam int VEC_N = 15;
  // gap before pulse, pulse width, expected link_n after it
  localparam int V_GAP [VEC_N] = '{10, 40, 40, 5, 200, 5, 5, 120, 250, 120, 30, 250, 30, 30, 250};
  localparam int V_WID [VEC_N] = '{ 1,  3,  3, 3,   3, 3, 3,   3,   3,   3,  3,   7,  4,  2,   5};
  localparam int V_EXP [VEC_N] = '{ 1,  1,  0, 0,   1, 1, 0,   0,   1,   1,  0,   1,  1,  0,   1};
  localparam string V_REQ [VEC_N] = '{"R1", "R3", "R4", "R2", "R5", "R2", "R2", "R3",
                                      "R5", "R3", "R4", "R1", "R1", "R1", "R1"};

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_pulse = 1'b0, rx_frame = 1'b0, tx_en = 1'b0, pol_rev = 1'b0;
  logic auto_sel = 1'b1, man_tp = 1'b0, standby = 1'b0;
  logic link_n, pol_n, flag_oe, lp, port_tp, port_oe, port_ready;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lnk_monitor #(.W_MIN(2), .W_MAX(4), .SEP_MIN(20), .SEP_MAX(100), .LOSS(150),
                .GOOD_BEATS(2), .TX_GAP(P_GAP), .TX_LEN(P_LEN), .SETTLE(P_SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_pulse_i(rx_pulse), .rx_frame_i(rx_frame),
    .tx_en_i(tx_en), .pol_rev_i(pol_rev), .auto_sel_i(auto_sel), .man_tp_i(man_tp),
    .standby_i(standby), .link_n_o(link_n), .pol_n_o(pol_n), .flag_oe_o(flag_oe),
    .lp_o(lp), .port_tp_o(port_tp), .port_oe_o(port_oe), .port_ready_o(port_ready));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_pulse(input int gap, input int wid);
    rx_pulse = 1'b0; tick(gap);
    rx_pulse = 1'b1; tick(wid);
    rx_pulse = 1'b0; tick(5);
  endtask

  task automatic link_up();
    send_pulse(40, 3);
    send_pulse(40, 3);
  endtask

  task automatic count_lp(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      tick(1);
      if (lp) hits++;
    end
  endtask

  task automatic wait_rise(input int limit, output int waited);
    logic prev;
    prev = lp;
    waited = -1;
    for (int i = 1; i <= limit; i++) begin
      tick(1);
      if (lp && !prev) begin waited = i; break; end
      prev = lp;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hits, w1, w2, wid;
    tick(3); rst_n = 1'b1; tick(1);
    // reset state
    chk("R4 reset link_n", int'(link_n), 1);
    chk("R10 reset pol_n", int'(pol_n), 1);
    chk("R7 reset port_tp", int'(port_tp), 0);
    chk("R9 reset ready", int'(port_ready), 1);
    chk("R6 reset lp", int'(lp), 0);

    // table walk: spacing and width of beats
    for (int v = 0; v < VEC_N; v++) begin
      send_pulse(V_GAP[v], V_WID[v]);
      chk(V_REQ[v], int'(link_n), V_EXP[v]);
    end

    // R1: pulse inside a frame is ignored
    send_pulse(40, 3);
    rx_frame = 1'b1; send_pulse(40, 3); rx_frame = 1'b0;
    chk("R1 pulse in frame ignored", int'(link_n), 1);

    // R5: frame activity keeps the link, silence drops it
    tick(200); link_up();
    chk("R4 link up", int'(link_n), 0);
    for (int i = 0; i < 4; i++) begin
      tick(100); rx_frame = 1'b1; tick(1); rx_frame = 1'b0;
    end
    chk("R5 frames refresh", int'(link_n), 0);
    tick(200);
    chk("R5 loss after silence", int'(link_n), 1);

    // R6: outgoing pulse period and width
    wait_rise(200, w1);
    wid = 0;
    while (lp && wid < 20) begin tick(1); wid++; end
    wait_rise(200, w2);
    chk("R6 pulse width", wid, P_LEN);
    chk("R6 pulse period", w2 + wid, P_GAP);
    tx_en = 1'b1; tick(2);
    count_lp(200, hits);
    chk("R6 quiet while transmitting", hits, 0);
    tx_en = 1'b0;
    wait_rise(200, w1);
    chk("R6 first pulse after idle", int'(w1 >= P_GAP - 2 && w1 <= P_GAP + 2), 1);

    // R8: manual AUI silences pulses, automatic AUI does not
    auto_sel = 1'b0; man_tp = 1'b0; tick(3);
    count_lp(200, hits);
    chk("R8 manual AUI no pulses", hits, 0);
    chk("R8 manual AUI port", int'(port_tp), 0);
    chk("R7 pin not driven in manual", int'(port_oe), 0);
    auto_sel = 1'b1; tick(3);
    count_lp(200, hits);
    chk("R8 auto AUI keeps pulses", int'(hits >= 2 * P_LEN), 1);

    // R7: automatic choice follows link
    link_up(); tick(2);
    chk("R7 auto picks TP", int'(port_tp), 1);
    chk("R7 pin driven", int'(port_oe), 1);
    chk("R11 flags enabled on TP", int'(flag_oe), 1);
    tick(200);
    chk("R7 auto falls back to AUI", int'(port_tp), 0);
    chk("R11 flags off on AUI", int'(flag_oe), 0);

    // R9: settle window
    auto_sel = 1'b0; man_tp = 1'b0; tick(P_SETTLE + 5);
    man_tp = 1'b1; tick(2);
    chk("R8 manual TP port", int'(port_tp), 1);
    chk("R9 not ready right after change", int'(port_ready), 0);
    tick(P_SETTLE - 4);
    chk("R9 still settling", int'(port_ready), 0);
    tick(5);
    chk("R9 ready after window", int'(port_ready), 1);

    // R10: polarity flag gating
    pol_rev = 1'b1; tick(2);
    chk("R10 forced high on failed link", int'(pol_n), 1);
    link_up();
    chk("R10 reversal reported", int'(pol_n), 0);
    pol_rev = 1'b0; tick(1);
    chk("R10 normal polarity", int'(pol_n), 1);

    // R11: standby
    standby = 1'b1; tick(2);
    chk("R11 flags off in standby", int'(flag_oe), 0);
    chk("R11 standby clears link", int'(link_n), 1);
    count_lp(150, hits);
    chk("R11 no pulses in standby", hits, 0);
    standby = 1'b0; tick(2);
    chk("R11 link stays down after standby", int'(link_n), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule